// File: doc/BRIEF.md
# Oscillator Coarse-Band Calibration Controller

This controller picks the capacitor-bank setting of a PLL oscillator before the loop is allowed to lock. The oscillator tunes in two parts: a switched-capacitor bank sets the band, and a varactor trims within it. Leaving reset, or on a start pulse, the controller holds the loop filter at its midpoint. It then walks the bank codes upward one at a time from zero.

For each code it waits a programmable settling time, counted in reference ticks. It then counts divided-oscillator ticks over a programmable window of reference ticks. The count is compared with the count a locked loop would give, which is the window length times the feedback ratio. The code with the smallest absolute error is remembered, and on a tie the lower code is kept. After the last code has been measured, the controller applies the best code and releases the filter hold. The loop then runs as an ordinary PLL using only the varactor. The done flag stays set until the next reset or start pulse.

Both clock inputs arrive as single-cycle ticks in the controller's own clock domain. Code zero has no capacitors switched in and so gives the highest frequency.

Top module: `vco_band_cal`

## Requirements
- R1: While reset is held, `coarse_code` is 0, `cal_busy` and `filt_hold` are 1 and `cal_done` is 0. Calibration begins on its own when reset is released, with no start pulse.
- R2: During a search, `coarse_code` starts at 0 and only ever rises by exactly 1. It visits all 32 values of the 5-bit code, 0 through 31.
- R3: Whenever `cal_busy` is 1, `filt_hold` is 1 and `cal_done` is 0.
- R4: A measurement window spans max(`win_len`,1) reference ticks and starts right after the reference tick that ends settling. All `vco_tick` pulses inside the window are counted. The target count is the window length times parameter `FB_RATIO`.
- R5: After each code change, settling lasts until the max(`settle_len`,1)-th reference tick. Oscillator ticks that arrive while settling have no effect on the chosen code.
- R6: The final code is the one whose count has the smallest absolute difference from the target. This holds even when an earlier code already lies on the other side of the target.
- R7: When several codes share the smallest error, the lowest of them is chosen.
- R8: Once code 31 has been measured, `coarse_code` shows the chosen code and `filt_hold` and `cal_busy` fall to 0. `cal_done` rises to 1, and it and the code hold steady until the next reset or start pulse.
- R9: A start pulse during a search sets `coarse_code` to 0 in the next cycle and reruns the full search, discarding earlier results.
- R10: A start pulse while done clears `cal_done` and raises `cal_busy` in the next cycle, then runs a fresh calibration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| start | input | 1 | One-cycle pulse that starts or restarts calibration |
| ref_tick | input | 1 | One-cycle pulse per reference clock edge |
| vco_tick | input | 1 | One-cycle pulse per divided-oscillator edge |
| win_len | input | WIN_W | Measurement window in reference ticks (0 acts as 1) |
| settle_len | input | SET_W | Settling time in reference ticks (0 acts as 1) |
| coarse_code | output | CODE_W | Capacitor-bank setting for the oscillator |
| filt_hold | output | 1 | Holds the loop filter at midpoint while high |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Calibration finished and the loop released |

## Verification
The bench builds a model oscillator that emits a number of ticks per reference period set by the current code. It sweeps four such curves:
- A falling staircase with a two-code plateau exactly on target tells a correct tie-break from a last-match choice.
- A steep staircase whose nearest step lies before the crossing tells a closest-match search from a first-crossing search.
- A flat curve makes every code tie.
- A slow curve puts the best plateau at the top of the range, which tests the end of the sweep.

Bursts of spurious oscillator ticks during every settling period expose a settle count that is too short. Window lengths of 1 (from a zero setting) up to 10 check the target scaling. Restarts both mid-search and after completion show that old results are thrown away.

// File: rtl/vco_band_cal.sv
module vco_band_cal #(
  parameter int CODE_W   = 5,
  parameter int WIN_W    = 8,
  parameter int SET_W    = 8,
  parameter int CNT_W    = 16,
  parameter int FB_RATIO = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ref_tick,
  input  logic              vco_tick,
  input  logic [WIN_W-1:0]  win_len,
  input  logic [SET_W-1:0]  settle_len,
  output logic [CODE_W-1:0] coarse_code,
  output logic              filt_hold,
  output logic              cal_busy,
  output logic              cal_done
);

  localparam int TW = (WIN_W > SET_W) ? WIN_W : SET_W;
  localparam logic [CODE_W-1:0] LAST_CODE = '1;
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

  typedef enum logic [1:0] {ST_SETTLE, ST_COUNT, ST_EVAL, ST_DONE} st_t;

  st_t               state;
  logic [TW-1:0]     tcnt;
  logic [CNT_W-1:0]  vcnt;
  logic [CNT_W-1:0]  best_err;
  logic [CODE_W-1:0] best_code;

  logic [TW-1:0]     win_eff, set_eff, tcnt_nx;
  logic [CNT_W-1:0]  target, err;
  logic              better;

  assign win_eff = (win_len == '0)    ? TW'(1) : TW'(win_len);
  assign set_eff = (settle_len == '0) ? TW'(1) : TW'(settle_len);
  assign tcnt_nx = tcnt + 1'b1;
  assign target  = CNT_W'(win_eff) * CNT_W'(FB_RATIO);
  assign err     = (vcnt >= target) ? (vcnt - target) : (target - vcnt);
  assign better  = (coarse_code == '0) || (err < best_err);

  assign cal_busy  = (state != ST_DONE);
  assign filt_hold = cal_busy;
  assign cal_done  = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      state       <= ST_SETTLE;
      coarse_code <= '0;
      tcnt        <= '0;
      vcnt        <= '0;
      best_err    <= '1;
      best_code   <= '0;
    end else begin
      unique case (state)
        ST_SETTLE: begin
          if (ref_tick) begin
            if (tcnt_nx == set_eff) begin
              state <= ST_COUNT;
              tcnt  <= '0;
              vcnt  <= '0;
            end else begin
              tcnt <= tcnt_nx;
            end
          end
        end
        ST_COUNT: begin
          if (vco_tick && vcnt != CNT_MAX) vcnt <= vcnt + 1'b1;
          if (ref_tick) begin
            if (tcnt_nx == win_eff) state <= ST_EVAL;
            else                    tcnt  <= tcnt_nx;
          end
        end
        ST_EVAL: begin
          if (better) begin
            best_err  <= err;
            best_code <= coarse_code;
          end
          if (coarse_code == LAST_CODE) begin
            state <= ST_DONE;
            if (!better) coarse_code <= best_code;
          end else begin
            coarse_code <= coarse_code + 1'b1;
            state       <= ST_SETTLE;
            tcnt        <= '0;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vco_band_cal_chk.sv
module vco_band_cal_chk #(
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CODE_W-1:0] coarse_code,
  input logic              filt_hold,
  input logic              cal_busy,
  input logic              cal_done
);

  a_r3_hold_in_search: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> (filt_hold && !cal_done));

  a_r8_release_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (!filt_hold && !cal_busy));

  a_r2_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && !$past(start) && coarse_code != $past(coarse_code))
      |-> coarse_code == $past(coarse_code) + 1'b1);

  a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (coarse_code == '0 && cal_busy));

  a_r8_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && $past(cal_done)) |-> $stable(coarse_code));

endmodule

bind vco_band_cal vco_band_cal_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .coarse_code(coarse_code),
  .filt_hold(filt_hold), .cal_busy(cal_busy), .cal_done(cal_done)
);

// File: tb/vco_band_cal_tb.sv
module vco_band_cal_tb;
  localparam int FB = 8;
  localparam int RP = 16;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       start = 0;
  logic       ref_tick = 0;
  logic       vco_tick = 0;
  logic [7:0] win_len = 8'd3;
  logic [7:0] settle_len = 8'd2;
  logic [4:0] coarse_code;
  logic       filt_hold, cal_busy, cal_done;

  vco_band_cal #(.CODE_W(5), .WIN_W(8), .SET_W(8), .CNT_W(16), .FB_RATIO(FB)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_tick(ref_tick), .vco_tick(vco_tick),
    .win_len(win_len), .settle_len(settle_len), .coarse_code(coarse_code),
    .filt_hold(filt_hold), .cal_busy(cal_busy), .cal_done(cal_done));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int g_mode = 0;

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  function automatic int kfun(input int mode, input int c);
    int v;
    case (mode)
      0: v = 15 - c / 2;
      1: v = 15 - 3 * (c / 2);
      2: v = 15;
      default: v = 15 - c / 4;
    endcase
    return (v < 0) ? 0 : v;
  endfunction

  function automatic int exp_code(input int mode, input int n);
    int best = -1, be = 0;
    for (int c = 0; c < 32; c++) begin
      int e = n * kfun(mode, c) - n * FB;
      if (e < 0) e = -e;
      if (best < 0 || e < be) begin best = c; be = e; end
    end
    return best;
  endfunction

  // model oscillator: spurious bursts while settling, code-dependent rate after
  int ph = 0, g_i = 0, g_k = 0, g_last = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      ph = RP - 1; g_i = 0; g_k = 0; g_last = 0;
      ref_tick = 0; vco_tick = 0;
    end else begin
      int s_eff;
      s_eff = (settle_len == 0) ? 1 : int'(settle_len);
      ph = (ph + 1) % RP;
      if (ph == 0) begin
        if (int'(coarse_code) != g_last) begin g_i = 0; g_last = int'(coarse_code); end
        if (g_i < 1000) g_i++;
        g_k = (g_i < s_eff) ? 15 : kfun(g_mode, int'(coarse_code));
        ref_tick = 1;
      end else begin
        ref_tick = 0;
      end
      vco_tick = (ph >= 1 && ph <= g_k);
    end
  end

  // search monitor
  int mon_prev = 0, mon_up = 0, mon_bad = 0, mon_hold_bad = 0;
  bit mon_clear = 0;
  always begin
    @(posedge clk) #2;
    if (mon_clear) begin
      mon_prev = int'(coarse_code); mon_up = 0; mon_bad = 0; mon_hold_bad = 0;
      mon_clear = 0;
    end else if (rst_n && cal_busy) begin
      if (int'(coarse_code) != mon_prev) begin
        if (int'(coarse_code) == mon_prev + 1) mon_up++; else mon_bad++;
      end
      if (!filt_hold || cal_done) mon_hold_bad++;
      mon_prev = int'(coarse_code);
    end
  end

  task automatic pulse_start();
    @(negedge clk);
    start = 1; mon_clear = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic finish_cal(input int exp, input string tag);
    int held;
    while (!cal_done) @(negedge clk);
    chk(mon_up == 31 && mon_bad == 0, "R2 linear sweep steps", mon_up, 31);
    chk(mon_hold_bad == 0, "R3 hold while busy", mon_hold_bad, 0);
    chk(int'(coarse_code) == exp, tag, int'(coarse_code), exp);
    chk(!filt_hold && !cal_busy, "R8 released at done", {filt_hold, cal_busy}, 0);
    held = int'(coarse_code);
    repeat (100) @(negedge clk);
    chk(cal_done && int'(coarse_code) == held, "R8 done and code held", int'(coarse_code), held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    g_mode = 0; settle_len = 8'd2; win_len = 8'd3;
    repeat (5) @(negedge clk);
    chk(coarse_code == 0 && cal_busy && filt_hold && !cal_done, "R1 reset state",
        {coarse_code, cal_busy, filt_hold, cal_done}, 6);
    rst_n = 1;
    @(negedge clk);
    chk(cal_busy && !cal_done, "R1 auto start after reset", cal_busy, 1);
    finish_cal(exp_code(0, 3), "R7 tie keeps lower code");

    g_mode = 1; settle_len = 8'd3; win_len = 8'd4;
    pulse_start();
    chk(!cal_done && cal_busy, "R10 start from done", cal_done, 0);
    finish_cal(exp_code(1, 4), "R6 R5 closest not first crossing");

    g_mode = 2; settle_len = 8'd1; win_len = 8'd2;
    pulse_start();
    finish_cal(exp_code(2, 2), "R7 all codes tie");

    g_mode = 3; settle_len = 8'd0; win_len = 8'd0;
    pulse_start();
    finish_cal(exp_code(3, 1), "R4 unit window best at top");

    g_mode = 1; settle_len = 8'd2; win_len = 8'd5;
    pulse_start();
    while (coarse_code != 5'd10) @(negedge clk);
    pulse_start();
    chk(coarse_code == 0 && cal_busy, "R9 restart mid search", int'(coarse_code), 0);
    finish_cal(exp_code(1, 5), "R9 result after restart");

    g_mode = 0; settle_len = 8'd4; win_len = 8'd10;
    pulse_start();
    finish_cal(exp_code(0, 10), "R4 R5 long window");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule